// File: doc/BRIEF.md
# Interrupt and I/O Event Logger

This block records the inputs of one processor that a later deterministic replay cannot reproduce by itself. Three sources feed it: the interrupt path, the instruction-level I/O path and the DMA write path. From each source it keeps only the events that a replay needs. An interrupt is kept, but a synchronous exception on the same channel is dropped. An I/O load is kept, but an I/O store is dropped. Every DMA word is kept.

Each kept event becomes one record on a single valid/ready output stream. A record holds a 2-bit kind tag, a data payload and a stamp. For interrupts and I/O loads, the stamp is the instruction count at which the event was taken. DMA behaves as its own pseudo-thread: its stamp is a private sequence count, numbered from zero.

Each source has a one-entry holding slot. When several sources fire together, the records leave in a fixed priority order. When the output is blocked, a full slot raises a stall to its own source, so no event is ever lost.

Top module: `event_logger`

## Requirements
- R1: After reset, `log_valid_o` and all three stall outputs are 0.
- R2: An interrupt (`irq_valid_i`=1, `irq_exc_i`=0) produces one record with tag 00. Its payload is `irq_type_i` zero-extended, and its stamp is `icount_i` of the cycle in which the interrupt was taken.
- R3: An exception (`irq_valid_i`=1, `irq_exc_i`=1) produces no record.
- R4: An I/O load (`io_valid_i`=1, `io_load_i`=1) produces one record with tag 01. Its payload is `io_data_i`, and its stamp is `icount_i` of the cycle in which the load was taken.
- R5: An I/O store (`io_valid_i`=1, `io_load_i`=0) produces no record.
- R6: Each DMA word produces one record with tag 10 and payload `dma_data_i`. Its stamp is the DMA sequence count, which is 0 for the first word after reset and rises by one for each word logged.
- R7: Events taken in the same cycle leave in this order: interrupt, then I/O load, then DMA.
- R8: An event taken at clock edge k is presented on the output after edge k+1, provided the output is free. A record that is presented stays unchanged until `log_ready_i` accepts it.
- R9: A source's stall is 1 while its slot is occupied and the slot cannot drain in this cycle. An event presented while its stall is 1 is not taken. The source holds that event, and it is logged later, so nothing is lost.
- R10: Tag 11 never appears on a valid record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| icount_i | input | IC_W | Current instruction count of the processor |
| irq_valid_i | input | 1 | Interrupt or exception is taken this cycle |
| irq_exc_i | input | 1 | 1 = synchronous exception (not logged) |
| irq_type_i | input | TYPE_W | Interrupt kind |
| irq_stall_o | output | 1 | Interrupt source must hold its event |
| io_valid_i | input | 1 | Instruction-level I/O access completes |
| io_load_i | input | 1 | 1 = load (logged), 0 = store (dropped) |
| io_data_i | input | DATA_W | Value returned by the I/O load |
| io_stall_o | output | 1 | I/O source must hold its event |
| dma_valid_i | input | 1 | DMA word is written into memory |
| dma_data_i | input | DATA_W | DMA word value |
| dma_stall_o | output | 1 | DMA source must hold its word |
| log_valid_o | output | 1 | Record is presented |
| log_ready_i | input | 1 | Sink accepts the record |
| log_tag_o | output | 2 | Record kind: 00 interrupt, 01 I/O load, 10 DMA |
| log_payload_o | output | DATA_W | Interrupt kind or data value |
| log_stamp_o | output | IC_W | Instruction count, or DMA sequence count |

## Verification
The assertions check the following on every cycle:
- a blocked record is held steady;
- no tag 11 appears;
- an exception or a store never fills an empty slot;
- DMA is granted only when no higher-priority slot is waiting;
- DMA stamps start at zero and then rise strictly by one.

Only the bench scenarios can show the record contents against the values that were driven, the exact output cycle, and the order of same-cycle mixtures. They also show that a held event under backpressure is logged after a stall, rather than lost or duplicated.

// File: rtl/elog_pkg.sv
package elog_pkg;
    localparam int NSRC = 3;
    localparam int SRC_IRQ = 0;
    localparam int SRC_IO  = 1;
    localparam int SRC_DMA = 2;

    typedef enum logic [1:0] {
        TAG_IRQ = 2'b00,
        TAG_IOL = 2'b01,
        TAG_DMA = 2'b10
    } tag_e;
endpackage

// File: rtl/elog_slot.sv
module elog_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         drain_i,
    input  logic [W-1:0] din_i,
    output logic         full_o,
    output logic [W-1:0] dout_o
);
    typedef struct packed {
        logic         full;
        logic [W-1:0] data;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (drain_i) s_d.full = 1'b0;
        if (load_i) begin
            s_d.full = 1'b1;
            s_d.data = din_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign full_o = s_q.full;
    assign dout_o = s_q.data;
endmodule

// File: rtl/elog_arb.sv
module elog_arb #(
    parameter int N = 3
) (
    input  logic         en_i,
    input  logic [N-1:0] req_i,
    output logic [N-1:0] gnt_o
);
    logic [N:0] blocked;
    assign blocked[0] = ~en_i;
    for (genvar i = 0; i < N; i++) begin : g_chain
        assign gnt_o[i]     = req_i[i] & ~blocked[i];
        assign blocked[i+1] = blocked[i] | req_i[i];
    end
endmodule

// File: rtl/event_logger.sv
module event_logger #(
    parameter int DATA_W = 16,
    parameter int IC_W   = 32,
    parameter int TYPE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IC_W-1:0]   icount_i,
    input  logic              irq_valid_i,
    input  logic              irq_exc_i,
    input  logic [TYPE_W-1:0] irq_type_i,
    output logic              irq_stall_o,
    input  logic              io_valid_i,
    input  logic              io_load_i,
    input  logic [DATA_W-1:0] io_data_i,
    output logic              io_stall_o,
    input  logic              dma_valid_i,
    input  logic [DATA_W-1:0] dma_data_i,
    output logic              dma_stall_o,
    output logic              log_valid_o,
    input  logic              log_ready_i,
    output logic [1:0]        log_tag_o,
    output logic [DATA_W-1:0] log_payload_o,
    output logic [IC_W-1:0]   log_stamp_o
);
    import elog_pkg::*;

    localparam int REC_W = 2 + DATA_W + IC_W;
    localparam int PAD_W = DATA_W - TYPE_W;

    typedef struct packed {
        logic             valid;
        logic [REC_W-1:0] rec;
        logic [IC_W-1:0]  seq;
    } st_t;

    st_t st_d, st_q;

    logic [NSRC-1:0]  want, take, full_w, grant_w, stall_w;
    logic [REC_W-1:0] din   [NSRC];
    logic [REC_W-1:0] dout  [NSRC];
    logic             out_free;

    assign out_free = ~st_q.valid | log_ready_i;

    assign want[SRC_IRQ] = irq_valid_i & ~irq_exc_i;
    assign want[SRC_IO]  = io_valid_i & io_load_i;
    assign want[SRC_DMA] = dma_valid_i;

    assign din[SRC_IRQ] = {TAG_IRQ, {PAD_W{1'b0}}, irq_type_i, icount_i};
    assign din[SRC_IO]  = {TAG_IOL, io_data_i, icount_i};
    assign din[SRC_DMA] = {TAG_DMA, dma_data_i, st_q.seq};

    elog_arb #(.N(NSRC)) u_arb (
        .en_i  (out_free),
        .req_i (full_w),
        .gnt_o (grant_w)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign stall_w[i] = full_w[i] & ~grant_w[i];
        assign take[i]    = want[i] & ~stall_w[i];
        elog_slot #(.W(REC_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_i  (take[i]),
            .drain_i (grant_w[i]),
            .din_i   (din[i]),
            .full_o  (full_w[i]),
            .dout_o  (dout[i])
        );
    end

    always_comb begin
        st_d = st_q;
        if (take[SRC_DMA]) st_d.seq = st_q.seq + 1'b1;
        if (out_free) begin
            st_d.valid = |grant_w;
            st_d.rec   = '0;
            for (int i = 0; i < NSRC; i++) begin
                if (grant_w[i]) st_d.rec = st_d.rec | dout[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_stall_o   = stall_w[SRC_IRQ];
    assign io_stall_o    = stall_w[SRC_IO];
    assign dma_stall_o   = stall_w[SRC_DMA];
    assign log_valid_o   = st_q.valid;
    assign log_tag_o     = st_q.rec[REC_W-1 -: 2];
    assign log_payload_o = st_q.rec[IC_W +: DATA_W];
    assign log_stamp_o   = st_q.rec[IC_W-1:0];
endmodule

// File: rtl/elog_chk.sv
module elog_chk #(
    parameter int DATA_W = 16,
    parameter int IC_W   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_valid_i,
    input logic              irq_exc_i,
    input logic              io_valid_i,
    input logic              io_load_i,
    input logic              log_valid_o,
    input logic              log_ready_i,
    input logic [1:0]        log_tag_o,
    input logic [DATA_W-1:0] log_payload_o,
    input logic [IC_W-1:0]   log_stamp_o,
    input logic [2:0]        full_w,
    input logic [2:0]        grant_w
);
    logic            seen_q;
    logic [IC_W-1:0] last_q;
    logic            dma_fire;

    assign dma_fire = log_valid_o & log_ready_i & (log_tag_o == 2'b10);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (dma_fire) begin
            seen_q <= 1'b1;
            last_q <= log_stamp_o;
        end
    end

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        log_valid_o && !log_ready_i |=> log_valid_o && $stable(log_tag_o)
            && $stable(log_payload_o) && $stable(log_stamp_o));

    // R10
    no_bad_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        log_valid_o |-> log_tag_o != 2'b11);

    // R3
    exc_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_i && irq_exc_i && !full_w[0] |=> !full_w[0]);

    // R5
    store_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_valid_i && !io_load_i && !full_w[1] |=> !full_w[1]);

    // R7
    dma_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_w[2] |-> !full_w[0] && !full_w[1]);

    // R6
    dma_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_fire && !seen_q |-> log_stamp_o == '0);

    // R6
    dma_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_fire && seen_q |-> log_stamp_o == last_q + 1'b1);
endmodule

bind event_logger elog_chk #(.DATA_W(DATA_W), .IC_W(IC_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .irq_valid_i   (irq_valid_i),
    .irq_exc_i     (irq_exc_i),
    .io_valid_i    (io_valid_i),
    .io_load_i     (io_load_i),
    .log_valid_o   (log_valid_o),
    .log_ready_i   (log_ready_i),
    .log_tag_o     (log_tag_o),
    .log_payload_o (log_payload_o),
    .log_stamp_o   (log_stamp_o),
    .full_w        (full_w),
    .grant_w       (grant_w)
);

// File: tb/tb_event_logger.sv
`timescale 1ns/1ps
module tb_event_logger;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] icount_i = '0;
    logic        irq_valid_i = 0, irq_exc_i = 0;
    logic [3:0]  irq_type_i = '0;
    logic        io_valid_i = 0, io_load_i = 0;
    logic [15:0] io_data_i = '0;
    logic        dma_valid_i = 0;
    logic [15:0] dma_data_i = '0;
    logic        log_ready_i = 1'b1;
    logic        irq_stall_o, io_stall_o, dma_stall_o, log_valid_o;
    logic [1:0]  log_tag_o;
    logic [15:0] log_payload_o;
    logic [31:0] log_stamp_o;

    always #2.5 clk = ~clk;

    event_logger dut (.*);

    int checks = 0, errors = 0;
    int exp_seq = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    logic [1:0]  cap_tag [16];
    logic [15:0] cap_pay [16];
    logic [31:0] cap_stp [16];
    int cap_n = 0;

    always @(negedge clk) begin
        if (rst_n && log_valid_o && log_ready_i && cap_n < 16) begin
            cap_tag[cap_n] = log_tag_o;
            cap_pay[cap_n] = log_payload_o;
            cap_stp[cap_n] = log_stamp_o;
            cap_n++;
        end
    end

    typedef struct packed {
        logic        iv; logic ie; logic [3:0] it;
        logic        ov; logic ol; logic [15:0] od;
        logic        dv; logic [15:0] dd;
        logic [31:0] ic;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VT [NV] = '{
        '{1'b1,1'b0,4'h3, 1'b0,1'b0,16'h0000, 1'b0,16'h0000, 32'd100},
        '{1'b1,1'b1,4'h5, 1'b0,1'b0,16'h0000, 1'b0,16'h0000, 32'd110},
        '{1'b0,1'b0,4'h0, 1'b1,1'b1,16'hBEEF, 1'b0,16'h0000, 32'd200},
        '{1'b0,1'b0,4'h0, 1'b1,1'b0,16'hDEAD, 1'b0,16'h0000, 32'd210},
        '{1'b0,1'b0,4'h0, 1'b0,1'b0,16'h0000, 1'b1,16'h1234, 32'd220},
        '{1'b1,1'b0,4'h9, 1'b1,1'b1,16'h55AA, 1'b1,16'h0F0F, 32'd300},
        '{1'b1,1'b1,4'h2, 1'b1,1'b0,16'h7777, 1'b1,16'hAAAA, 32'd310},
        '{1'b1,1'b0,4'hF, 1'b1,1'b0,16'h1111, 1'b0,16'h0000, 32'hFFFFFFFF}
    };

    task automatic apply(input vec_t v);
        @(negedge clk);
        icount_i = v.ic;
        irq_valid_i = v.iv; irq_exc_i = v.ie; irq_type_i = v.it;
        io_valid_i = v.ov; io_load_i = v.ol; io_data_i = v.od;
        dma_valid_i = v.dv; dma_data_i = v.dd;
        @(negedge clk);
        irq_valid_i = 0; io_valid_i = 0; dma_valid_i = 0;
    endtask

    task automatic expect_rec(input int idx, input logic [1:0] tg, input logic [15:0] pl,
                              input logic [31:0] sp, input string req);
        chk(cap_tag[idx] == tg, req, cap_tag[idx], tg);
        chk(cap_pay[idx] == pl, req, cap_pay[idx], pl);
        chk(cap_stp[idx] == sp, req, cap_stp[idx], sp);
    endtask

    task automatic send_dma(input logic [15:0] d);
        bit st;
        @(negedge clk);
        dma_valid_i = 1; dma_data_i = d;
        forever begin
            #1 st = dma_stall_o;
            @(posedge clk);
            if (!st) break;
            @(negedge clk);
        end
        @(negedge clk);
        dma_valid_i = 0;
    endtask

    initial begin
        int n;
        #10000000;
        errors++; checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(log_valid_o == 0, "R1", log_valid_o, 0);
        chk({irq_stall_o, io_stall_o, dma_stall_o} == 0, "R1",
            {irq_stall_o, io_stall_o, dma_stall_o}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(log_valid_o == 0, "R1", log_valid_o, 0);

        // vector table walk: R2 R3 R4 R5 R6 R7
        for (int k = 0; k < NV; k++) begin
            vec_t v;
            int n;
            v = VT[k];
            cap_n = 0;
            apply(v);
            repeat (6) @(negedge clk);
            n = 0;
            if (v.iv && !v.ie) begin
                if (cap_n > n) expect_rec(n, 2'b00, {12'h0, v.it}, v.ic, "R2/R7");
                n++;
            end
            if (v.ov && v.ol) begin
                if (cap_n > n) expect_rec(n, 2'b01, v.od, v.ic, "R4/R7");
                n++;
            end
            if (v.dv) begin
                if (cap_n > n) expect_rec(n, 2'b10, v.dd, exp_seq, "R6/R7");
                n++;
                exp_seq++;
            end
            // R3 R5: filtered events add no records
            chk(cap_n == n, "R3/R5 record count", cap_n, n);
        end

        // R8 latency: taken at edge k, visible after edge k+1
        cap_n = 0;
        @(negedge clk);
        icount_i = 32'd555; irq_valid_i = 1; irq_exc_i = 0; irq_type_i = 4'h6;
        @(negedge clk);
        irq_valid_i = 0;
        chk(log_valid_o == 0, "R8 early", log_valid_o, 0);
        @(negedge clk);
        chk(log_valid_o == 1, "R8 on time", log_valid_o, 1);
        chk(log_stamp_o == 32'd555, "R8/R2 stamp", log_stamp_o, 555);
        repeat (3) @(negedge clk);

        // R9 backpressure on DMA, R8 hold, R6 sequence continuity
        cap_n = 0;
        log_ready_i = 0;
        send_dma(16'hA001);
        send_dma(16'hA002);
        @(negedge clk);
        #1;
        chk(dma_stall_o == 1, "R9 stall raised", dma_stall_o, 1);
        chk(irq_stall_o == 0, "R9 other source", irq_stall_o, 0);
        dma_valid_i = 1; dma_data_i = 16'hA003;
        repeat (3) @(negedge clk);
        chk(log_valid_o == 1 && log_payload_o == 16'hA001, "R8 hold", log_payload_o, 16'hA001);
        chk(dma_stall_o == 1, "R9 stall held", dma_stall_o, 1);
        log_ready_i = 1;
        @(posedge clk);
        @(negedge clk);
        dma_valid_i = 0;
        repeat (6) @(negedge clk);
        chk(cap_n == 3, "R9 no loss", cap_n, 3);
        if (cap_n == 3) begin
            expect_rec(0, 2'b10, 16'hA001, exp_seq,     "R9/R6");
            expect_rec(1, 2'b10, 16'hA002, exp_seq + 1, "R9/R6");
            expect_rec(2, 2'b10, 16'hA003, exp_seq + 2, "R9/R6");
        end
        exp_seq += 3;
        // R10 tag check on captured records
        for (int k = 0; k < cap_n; k++) chk(cap_tag[k] != 2'b11, "R10", cap_tag[k], 2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule